// File: doc/BRIEF.md
# Split Accumulator Datapath with Condition Codes

This block is the arithmetic core of a small processor whose external data bus is one byte wide. It keeps two 8-bit accumulators, called A and B, and lets every operation address them either one at a time or as a single 16-bit double accumulator D. D has no storage of its own. A always supplies bits 15:8 of D and B supplies bits 7:0, so every 16-bit result updates both bytes on the same clock edge. A shared ALU runs each operation at byte width or at word width. A 4-bit condition-code register records the status of the most recent flag-setting operation. Results never pass through that register; it only feeds its carry back into add-with-carry.

An outer sequencer presents one operation per cycle. It supplies a 4-bit code, a width select, an accumulator select for byte operations, a memory operand that has already been fetched, and an address for stores. The operation takes effect when `opValid` is high at a rising clock edge. A store of D is split into two byte writes on consecutive cycles. The high byte goes out first, at the given address. The low byte follows at the next address. Both bytes are captured at issue, so the accumulators are free for the next operation while the second byte is still on the bus.

Top module: `splitacc_core`

## Requirements
- R1: After reset A, B and all four flags are zero, `busWr` is low and `busy` is low.
- R2: `accD` always equals {A, B}. A word-width result updates A and B on the same edge. A byte-width result updates only the accumulator picked by `regSel` (0 = A, 1 = B).
- R3: Codes 1 (add), 2 (add with carry) and 3 (subtract) combine the target with the operand at the chosen width. Add-with-carry also adds the C flag left by the previous flag-setting operation. Flags are {N,Z,V,C}. N is the result's top bit and Z marks a zero result. V is signed overflow. C is the carry out, or for subtract the borrow.
- R4: Code 4 (compare) sets the flags exactly as subtract would and writes no accumulator.
- R5: Codes 5 (increment) and 6 (decrement) change the target by one. C is set when the value wraps: increment from all ones, or decrement from zero. V is set when the value crosses the signed boundary.
- R6: Code 7 shifts left and code 8 shifts right logically. On a word-width left shift, bit 7 of B moves into bit 0 of A. C receives the bit shifted out, and V equals N xor C.
- R7: Code 9 places the unsigned 16-bit product A×B in D. Z reflects the product, C takes product bit 7, and N and V are kept.
- R8: Code 0 loads the operand into the target (D at word width) and leaves the flags unchanged.
- R9: Code 10 at word width writes A to `storeAddr` on the cycle after issue. It then writes B to `storeAddr`+1 (modulo 2^16) on the following cycle. The bytes written are the values held at issue, and `busy` is high during the second byte.
- R10: Code 10 at byte width writes the selected accumulator to `storeAddr` in a single cycle and does not raise `busy`.
- R11: A store issued while `busy` is high is dropped. Any other operation issued while `busy` is high executes normally.
- R12: Codes 11 to 15, and any cycle with `opValid` low, change no accumulator, flag or bus output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Executes the presented operation at this edge |
| opCode | input | 4 | Operation code (see requirements) |
| wide | input | 1 | 1 = operate on D, 0 = operate on one byte |
| regSel | input | 1 | Byte target: 0 = A, 1 = B |
| memOperand | input | 16 | Operand; low byte used at byte width |
| storeAddr | input | 16 | Address of the first stored byte |
| accA | output | 8 | Accumulator A |
| accB | output | 8 | Accumulator B |
| accD | output | 16 | Double accumulator view {A, B} |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Overflow flag |
| flagC | output | 1 | Carry / borrow flag |
| busy | output | 1 | Second byte of a word store in progress |
| busWr | output | 1 | Byte write strobe |
| busAddr | output | 16 | Byte write address |
| busData | output | 8 | Byte write data |

## Verification
Two activities can share a cycle: the second byte of a word store, and an operation that rewrites A and B. The bench starts a word store of a known D. In the very next cycle it issues a word load of a different value, so the low byte leaves on the bus in the same cycle that B is rewritten. The check passes only if the bus carries the low byte that B held at issue, at the incremented address, while `accD` already shows the new load. A second store issued during that cycle must leave no trace on the bus afterwards.

// File: rtl/splitacc_pkg.sv
package splitacc_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int OPC_W  = 4;
  localparam int FLAG_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_LD  = 4'd0,
    OP_ADD = 4'd1,
    OP_ADC = 4'd2,
    OP_SUB = 4'd3,
    OP_CMP = 4'd4,
    OP_INC = 4'd5,
    OP_DEC = 4'd6,
    OP_ASL = 4'd7,
    OP_LSR = 4'd8,
    OP_MUL = 4'd9,
    OP_ST  = 4'd10
  } aluOp_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  typedef struct packed {
    aluOp_e              op;
    logic                wide;
    logic                sel;
    logic                wrA;
    logic                wrB;
    logic [FLAG_W-1:0]   flagMask;
    logic                useMul;
    logic                busFirst;
    logic                busSecond;
  } strobe_t;

endpackage

// File: rtl/splitacc_alu.sv
module splitacc_alu
  import splitacc_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  aluOp_e       op,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] res,
  output flags_t       fl
);

  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W:0] sum;

  always_comb begin
    sum  = '0;
    res  = y;
    fl.c = cin;
    fl.v = 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin
        sum  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, (op == OP_ADC) & cin};
        res  = sum[W-1:0];
        fl.c = sum[W];
        fl.v = (x[W-1] == y[W-1]) && (res[W-1] != x[W-1]);
      end
      OP_SUB, OP_CMP: begin
        sum  = {1'b0, x} + {1'b0, ~y} + {{W{1'b0}}, 1'b1};
        res  = sum[W-1:0];
        fl.c = ~sum[W];
        fl.v = (x[W-1] != y[W-1]) && (res[W-1] != x[W-1]);
      end
      OP_INC: begin
        res  = x + ONE;
        fl.c = &x;
        fl.v = (x == MAX_POS);
      end
      OP_DEC: begin
        res  = x - ONE;
        fl.c = ~|x;
        fl.v = (x == MIN_NEG);
      end
      OP_ASL: begin
        res  = {x[W-2:0], 1'b0};
        fl.c = x[W-1];
        fl.v = x[W-2] ^ x[W-1];
      end
      OP_LSR: begin
        res  = {1'b0, x[W-1:1]};
        fl.c = x[0];
        fl.v = x[0];
      end
      default: res = y;
    endcase
    fl.n = res[W-1];
    fl.z = ~|res;
  end

endmodule

// File: rtl/splitacc_ctrl.sv
module splitacc_ctrl
  import splitacc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [OPC_W-1:0] opCode,
  input  logic             wide,
  input  logic             regSel,
  output strobe_t          strobe,
  output logic             busy
);

  logic stPending;

  always_comb begin
    strobe           = '0;
    strobe.op        = aluOp_e'(opCode);
    strobe.wide      = wide;
    strobe.sel       = regSel;
    strobe.busSecond = stPending;
    if (opValid) begin
      case (opCode)
        OP_LD: begin
          strobe.wrA = wide | ~regSel;
          strobe.wrB = wide | regSel;
        end
        OP_ADD, OP_ADC, OP_SUB, OP_INC, OP_DEC, OP_ASL, OP_LSR: begin
          strobe.wrA      = wide | ~regSel;
          strobe.wrB      = wide | regSel;
          strobe.flagMask = 4'b1111;
        end
        OP_CMP: strobe.flagMask = 4'b1111;
        OP_MUL: begin
          strobe.wrA      = 1'b1;
          strobe.wrB      = 1'b1;
          strobe.useMul   = 1'b1;
          strobe.flagMask = 4'b0101;
        end
        OP_ST:   strobe.busFirst = ~stPending;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stPending <= 1'b0;
    else       stPending <= strobe.busFirst & wide;
  end

  assign busy = stPending;

endmodule

// File: rtl/splitacc_dp.sv
module splitacc_dp
  import splitacc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [WORD_W-1:0] memOperand,
  input  logic [ADDR_W-1:0] storeAddr,
  output logic [BYTE_W-1:0] regA,
  output logic [BYTE_W-1:0] regB,
  output logic [FLAG_W-1:0] ccr,
  output logic              busWr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BYTE_W-1:0] busData
);

  localparam logic [ADDR_W-1:0] ADDR_STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [BYTE_W-1:0] res8;
  logic [WORD_W-1:0] res16;
  flags_t            fl8, fl16, flNew;
  logic [WORD_W-1:0] prod, newD;
  logic [BYTE_W-1:0] selByte;
  logic [BYTE_W-1:0] lowData;
  logic [ADDR_W-1:0] lowAddr;

  assign selByte = strobe.sel ? regB : regA;

  splitacc_alu #(.W(BYTE_W)) u_alu8 (
    .op (strobe.op),
    .x  (selByte),
    .y  (memOperand[BYTE_W-1:0]),
    .cin(ccr[0]),
    .res(res8),
    .fl (fl8)
  );

  splitacc_alu #(.W(WORD_W)) u_alu16 (
    .op (strobe.op),
    .x  ({regA, regB}),
    .y  (memOperand),
    .cin(ccr[0]),
    .res(res16),
    .fl (fl16)
  );

  assign prod = regA * regB;

  always_comb begin
    if (strobe.useMul) begin
      newD    = prod;
      flNew   = flags_t'(ccr);
      flNew.z = ~|prod;
      flNew.c = prod[BYTE_W-1];
    end else if (strobe.wide) begin
      newD  = res16;
      flNew = fl16;
    end else begin
      newD  = {res8, res8};
      flNew = fl8;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA <= '0;
      regB <= '0;
      ccr  <= '0;
    end else begin
      if (strobe.wrA) regA <= newD[WORD_W-1:BYTE_W];
      if (strobe.wrB) regB <= newD[BYTE_W-1:0];
      ccr <= (ccr & ~strobe.flagMask) | (flNew & strobe.flagMask);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busWr   <= 1'b0;
      busAddr <= '0;
      busData <= '0;
      lowData <= '0;
      lowAddr <= '0;
    end else begin
      busWr <= 1'b0;
      if (strobe.busSecond) begin
        busWr   <= 1'b1;
        busAddr <= lowAddr;
        busData <= lowData;
      end else if (strobe.busFirst) begin
        busWr   <= 1'b1;
        busAddr <= storeAddr;
        busData <= strobe.wide ? regA : selByte;
        lowData <= regB;
        lowAddr <= storeAddr + ADDR_STEP;
      end
    end
  end

endmodule

// File: rtl/splitacc_core.sv
module splitacc_core
  import splitacc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OPC_W-1:0]  opCode,
  input  logic              wide,
  input  logic              regSel,
  input  logic [WORD_W-1:0] memOperand,
  input  logic [ADDR_W-1:0] storeAddr,
  output logic [BYTE_W-1:0] accA,
  output logic [BYTE_W-1:0] accB,
  output logic [WORD_W-1:0] accD,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC,
  output logic              busy,
  output logic              busWr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BYTE_W-1:0] busData
);

  strobe_t           strobe;
  logic [FLAG_W-1:0] ccr;

  splitacc_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opValid(opValid),
    .opCode (opCode),
    .wide   (wide),
    .regSel (regSel),
    .strobe (strobe),
    .busy   (busy)
  );

  splitacc_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .memOperand(memOperand),
    .storeAddr (storeAddr),
    .regA      (accA),
    .regB      (accB),
    .ccr       (ccr),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busData   (busData)
  );

  assign accD  = {accA, accB};
  assign flagN = ccr[3];
  assign flagZ = ccr[2];
  assign flagV = ccr[1];
  assign flagC = ccr[0];

endmodule

// File: rtl/splitacc_core_chk.sv
module splitacc_core_chk
  import splitacc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [OPC_W-1:0]  opCode,
  input logic              wide,
  input logic              regSel,
  input logic [WORD_W-1:0] memOperand,
  input logic [ADDR_W-1:0] storeAddr,
  input logic [BYTE_W-1:0] accA,
  input logic [BYTE_W-1:0] accB,
  input logic [WORD_W-1:0] accD,
  input logic              flagN,
  input logic              flagZ,
  input logic              flagV,
  input logic              flagC,
  input logic              busy,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BYTE_W-1:0] busData
);

  logic [FLAG_W-1:0] flagsNow;
  assign flagsNow = {flagN, flagZ, flagV, flagC};

  p_wide_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_LD && wide) |=> (accA == $past(memOperand[WORD_W-1:BYTE_W]) && accB == $past(memOperand[BYTE_W-1:0])));

  p_byte_load_keeps_other_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_LD && !wide && !regSel) |=> $stable(accB));

  p_cmp_no_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMP) |=> $stable(accD));

  p_mul_product_r7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_MUL) |=> (accD == $past(accA) * $past(accB)));

  p_load_keeps_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_LD) |=> $stable(flagsNow));

  p_store_first_r9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_ST && wide && !busy) |=> (busWr && busy && busAddr == $past(storeAddr) && busData == $past(accA)));

  p_store_second_r9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_ST && wide && !busy) |=> ##1 (busWr && busAddr == $past(storeAddr, 2) + 16'd1 && busData == $past(accB, 2)));

  p_busy_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && !busy) |=> (!busWr && $stable(accD) && $stable(flagsNow)));

endmodule

bind splitacc_core splitacc_core_chk u_chk (.*);

// File: tb/splitacc_core_bench.sv
module splitacc_core_bench;
  import splitacc_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic        wide = 1'b0;
  logic        regSel = 1'b0;
  logic [15:0] memOperand = '0;
  logic [15:0] storeAddr = '0;
  logic [7:0]  accA, accB, busData;
  logic [15:0] accD, busAddr;
  logic        flagN, flagZ, flagV, flagC, busy, busWr;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  splitacc_core u_splitacc_core (.*);

  // op, wide, sel, operand, expected D, expected {N,Z,V,C}
  localparam int NV = 24;
  localparam logic [41:0] VEC [NV] = '{
    {4'd0, 1'b1, 1'b0, 16'h1234, 16'h1234, 4'b0000},
    {4'd1, 1'b1, 1'b0, 16'hEDCC, 16'h0000, 4'b0101},
    {4'd2, 1'b0, 1'b0, 16'h007F, 16'h8000, 4'b1010},
    {4'd3, 1'b0, 1'b1, 16'h0001, 16'h80FF, 4'b1001},
    {4'd4, 1'b1, 1'b0, 16'h80FF, 16'h80FF, 4'b0100},
    {4'd7, 1'b1, 1'b0, 16'h0000, 16'h01FE, 4'b0011},
    {4'd8, 1'b1, 1'b0, 16'h0000, 16'h00FF, 4'b0000},
    {4'd5, 1'b1, 1'b0, 16'h0000, 16'h0100, 4'b0000},
    {4'd6, 1'b0, 1'b0, 16'h0000, 16'h0000, 4'b0100},
    {4'd6, 1'b0, 1'b0, 16'h0000, 16'hFF00, 4'b1001},
    {4'd5, 1'b0, 1'b1, 16'h0000, 16'hFF01, 4'b0000},
    {4'd0, 1'b0, 1'b1, 16'h00FF, 16'hFFFF, 4'b0000},
    {4'd9, 1'b0, 1'b0, 16'h0000, 16'hFE01, 4'b0000},
    {4'd0, 1'b0, 1'b0, 16'h0010, 16'h1001, 4'b0000},
    {4'd0, 1'b0, 1'b1, 16'h0088, 16'h1088, 4'b0000},
    {4'd9, 1'b0, 1'b0, 16'h0000, 16'h0880, 4'b0001},
    {4'd1, 1'b1, 1'b0, 16'h7800, 16'h8080, 4'b1010},
    {4'd0, 1'b1, 1'b0, 16'h7FFF, 16'h7FFF, 4'b1010},
    {4'd5, 1'b1, 1'b0, 16'h0000, 16'h8000, 4'b1010},
    {4'd3, 1'b1, 1'b0, 16'h0001, 16'h7FFF, 4'b0010},
    {4'd12, 1'b1, 1'b0, 16'h1111, 16'h7FFF, 4'b0010},
    {4'd0, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 4'b0010},
    {4'd5, 1'b1, 1'b0, 16'h0000, 16'h0000, 4'b0101},
    {4'd6, 1'b1, 1'b0, 16'h0000, 16'hFFFF, 4'b1001}
  };

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0: return "R8";
      4'd1, 4'd2, 4'd3: return "R3";
      4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7, 4'd8: return "R6";
      4'd9: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic w, input logic s, input logic [15:0] opnd, input logic [15:0] addr);
    opValid = 1'b1; opCode = op; wide = w; regSel = s; memOperand = opnd; storeAddr = addr;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1", "accD after reset", accD, 16'h0000);
    check("R1", "flags after reset", {12'h0, flagN, flagZ, flagV, flagC}, 16'h0000);
    check("R1", "busWr/busy after reset", {14'h0, busWr, busy}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][41:38], VEC[i][37], VEC[i][36], VEC[i][35:20], 16'h0000);
      check(reqOf(VEC[i][41:38]), "accD (R2 alias)", accD, VEC[i][19:4]);
      check(reqOf(VEC[i][41:38]), "flags", {12'h0, flagN, flagZ, flagV, flagC}, {12'h0, VEC[i][3:0]});
      check("R2", "accD equals {A,B}", accD, {accA, accB});
    end

    // R12: opValid low with a live opcode
    opCode = 4'd1; wide = 1'b1; memOperand = 16'h1111;
    @(negedge clk);
    check("R12", "accD with opValid low", accD, 16'hFFFF);
    check("R12", "busWr with opValid low", {15'h0, busWr}, 16'h0000);

    // R9: word store at top of address space, collides with a word load
    issue(4'd0, 1'b1, 1'b0, 16'hA55A, 16'h0000);
    issue(4'd10, 1'b1, 1'b0, 16'h0000, 16'hFFFF);
    check("R9", "first byte strobe/busy", {14'h0, busWr, busy}, 16'h0003);
    check("R9", "first byte addr", busAddr, 16'hFFFF);
    check("R9", "first byte data", {8'h0, busData}, 16'h00A5);
    issue(4'd0, 1'b1, 1'b0, 16'h1234, 16'h0000);
    check("R9", "second byte strobe", {15'h0, busWr}, 16'h0001);
    check("R9", "second byte addr wraps", busAddr, 16'h0000);
    check("R9", "second byte is old B", {8'h0, busData}, 16'h005A);
    check("R11", "load during busy executes", accD, 16'h1234);
    @(negedge clk);
    check("R9", "bus idle after store", {14'h0, busWr, busy}, 16'h0000);

    // R11: store issued while busy is dropped
    issue(4'd10, 1'b1, 1'b0, 16'h0000, 16'h0100);
    check("R9", "byte A at 0x0100", {busAddr[7:0], busData}, 16'h0012);
    issue(4'd10, 1'b0, 1'b0, 16'h0000, 16'h0200);
    check("R9", "byte B at 0x0101", {busAddr[7:0], busData}, 16'h0134);
    check("R11", "second-byte address", busAddr, 16'h0101);
    @(negedge clk);
    check("R11", "dropped store leaves bus idle", {14'h0, busWr, busy}, 16'h0000);

    // R10: byte store of B
    issue(4'd10, 1'b0, 1'b1, 16'h0000, 16'h0300);
    check("R10", "byte store strobe, no busy", {14'h0, busWr, busy}, 16'h0002);
    check("R10", "byte store addr", busAddr, 16'h0300);
    check("R10", "byte store data", {8'h0, busData}, 16'h0034);
    @(negedge clk);
    check("R10", "single cycle", {14'h0, busWr, busy}, 16'h0000);
    check("R10", "store writes no register", accD, 16'h1234);

    finish();
  end

endmodule